// File: doc/BRIEF.md
# NOR Flash Storage Program/Erase Engine

This block holds the contents of a serial NOR flash in an on-chip byte array and applies the operations that a command decoder in front of it has already parsed. It takes program requests, erase requests and read addresses. Programs may cover a whole byte or only a field of 1 to 8 bits inside one byte. Erase requests arrive as the raw erase opcode plus a start address. Reads return one byte per cycle.

Flash behaviour is the default. A program can only clear bits, and an erase sets a whole aligned region back to 0xFF, one byte per cycle, while a busy output is high. An overwrite mode makes a program replace the old bits instead of clearing them. A write-enable input gates every change to the array. A page tracker tells the backing store when a page has to be committed: either the next program goes to a different page, or the chip select is released.

Top module: `nor_array_engine`

## Requirements
- R1: An accepted, enabled erase sets every byte of a region of its size, aligned down to that size, to 0xFF. The fill runs one byte per cycle. Bytes outside the region keep their values.
- R2: Opcode 0x20 selects the small region (2^SUB_W bytes) and 0x52 the medium region (2^MID_W bytes). 0xD8 and 0xDC select one sector (2^SECT_W bytes). 0x60 and 0xC7 select the whole array. Any other opcode is ignored: no busy, no error, no change.
- R3: An erase request with `wr_en_i` low changes no byte and does not raise `busy_o`.
- R4: When an accepted request selects a small or medium erase that the part lacks (parameter CAP_SUB or CAP_MID is 0), `erase_err_o` pulses high for one cycle, one cycle after the request. This happens whether or not `wr_en_i` is high. With write enable the erase is still performed.
- R5: `busy_o` rises in the cycle after an enabled erase is accepted and stays high for max(region size, BUSY_CYCLES) cycles. Erase and program requests that arrive while `busy_o` is high are ignored.
- R6: With `ovw_mode_i` low, a program stores old AND new in the targeted bits, so no bit ever goes from 0 to 1.
- R7: With `ovw_mode_i` high, a program replaces the targeted bits with the new data.
- R8: A program writes the low `prog_nbits_i` bits of `prog_data_i` into the byte. The field's most significant bit lands at bit position 7 - `prog_off_i`, with bit 7 as the byte's MSB. Bits outside the field are unchanged. A request with a count of 0, or with offset + count > 8, is ignored.
- R9: A program is accepted only when `wr_en_i` is high, `cs_n_i` is low, `busy_o` is low and no erase request arrives in the same cycle.
- R10: `warn_o` becomes 1 after an accepted flash-mode program that tries to turn a stored 0 into a 1. It stays 1 until reset. Overwrite-mode programs never set it.
- R11: An accepted program to a page (2^PAGE_W bytes) other than the page that is currently dirty pulses `commit_o` for one cycle, with the old page index on `commit_page_o`. The new page then becomes the dirty page.
- R12: A rising edge on `cs_n_i` while a page is dirty pulses `commit_o` with that page index and leaves nothing dirty. A rising edge with nothing dirty does not pulse.
- R13: `rd_data_o` shows the byte at `rd_addr_i` one cycle later. After reset the whole array reads 0xFF, and `busy_o`, `erase_err_o`, `warn_o` and `commit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low; a rising edge commits the dirty page |
| wr_en_i | input | 1 | Write enable that gates program and erase |
| ovw_mode_i | input | 1 | 1: program replaces bits; 0: program ANDs bits |
| prog_req_i | input | 1 | Program request |
| prog_addr_i | input | ADDR_W | Program byte address |
| prog_off_i | input | 3 | Bit offset of the field, counted from the MSB |
| prog_nbits_i | input | 4 | Field width, 1 to 8 |
| prog_data_i | input | 8 | Field data, right-aligned |
| erase_req_i | input | 1 | Erase request |
| erase_op_i | input | 8 | Erase opcode |
| erase_addr_i | input | ADDR_W | Erase start address |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 8 | Read data, one cycle of latency |
| busy_o | output | 1 | Erase in progress |
| erase_err_o | output | 1 | Pulse: unsupported erase size requested |
| warn_o | output | 1 | Sticky: a 0-to-1 program was attempted |
| commit_o | output | 1 | Pulse: page on commit_page_o must be committed |
| commit_page_o | output | ADDR_W-PAGE_W | Index of the page to commit |

## Verification
The bench builds the block with a 1 KiB array, 32-byte pages and regions of 64, 128 and 256 bytes, with BUSY_CYCLES at 100. This shrinks the array so that full-array sweeps after each erase, and a whole-chip erase, stay short. A busy window of 100 cycles lies between the small region (the timer sets the busy length) and the medium and sector regions (the fill sets it), so both paths that end busy are exercised. The small size is built as supported and the medium size as unsupported, which makes the error pulse visible both with and without the actual fill.

// File: rtl/nor_eng_pkg.sv
package nor_eng_pkg;

  typedef enum logic [2:0] {
    EK_NONE,
    EK_SUB,
    EK_MID,
    EK_SECT,
    EK_CHIP
  } ers_kind_e;

  function automatic ers_kind_e decode_erase(input logic [7:0] op);
    ers_kind_e k;
    case (op)
      8'h20:        k = EK_SUB;
      8'h52:        k = EK_MID;
      8'hD8, 8'hDC: k = EK_SECT;
      8'h60, 8'hC7: k = EK_CHIP;
      default:      k = EK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/nor_bit_merge.sv
module nor_bit_merge (
  input  logic [7:0] old_i,
  input  logic [7:0] data_i,
  input  logic [2:0] off_i,
  input  logic [3:0] nbits_i,
  input  logic       ovw_i,
  output logic       legal_o,
  output logic [7:0] new_o,
  output logic       rise_o
);
  logic [4:0] span;
  logic [3:0] sh;
  logic [8:0] ones;
  logic [7:0] mask;
  logic [7:0] fld;

  always_comb begin
    span    = {2'b00, off_i} + {1'b0, nbits_i};
    legal_o = (nbits_i != 4'd0) && (span <= 5'd8);
    sh      = 4'd8 - {1'b0, off_i} - nbits_i;
    ones    = (9'd1 << nbits_i) - 9'd1;
    mask    = legal_o ? (ones[7:0] << sh) : 8'h00;
    fld     = (data_i << sh) & mask;
    if (ovw_i) new_o = (old_i & ~mask) | fld;
    else       new_o = old_i & (fld | ~mask);
    rise_o  = !ovw_i && |(~old_i & fld);
  end

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_eng_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned SUB_W       = 8,
  parameter int unsigned MID_W       = 9,
  parameter int unsigned SECT_W      = 10,
  parameter int unsigned BUSY_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  ers_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = ADDR_W + 1;
  localparam int unsigned TMR_W = $clog2(BUSY_CYCLES + 2);
  localparam logic [CNT_W-1:0] LEN_SUB  = CNT_W'(1) << SUB_W;
  localparam logic [CNT_W-1:0] LEN_MID  = CNT_W'(1) << MID_W;
  localparam logic [CNT_W-1:0] LEN_SECT = CNT_W'(1) << SECT_W;
  localparam logic [CNT_W-1:0] LEN_CHIP = CNT_W'(1) << ADDR_W;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(BUSY_CYCLES);

  logic [CNT_W-1:0]  len;
  logic [ADDR_W-1:0] span_m1;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              load;

  always_comb begin
    case (kind_i)
      EK_SUB:  len = LEN_SUB;
      EK_MID:  len = LEN_MID;
      EK_SECT: len = LEN_SECT;
      EK_CHIP: len = LEN_CHIP;
      default: len = '0;
    endcase
    span_m1 = ADDR_W'(len - CNT_W'(1));
    base    = addr_i & ~span_m1;
    load    = start_i && (kind_i != EK_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
      tmr_q <= '0;
    end else if (load) begin
      cnt_q <= len;
      ptr_q <= base;
      tmr_q <= TMR_LOAD;
    end else begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        ptr_q <= ptr_q + ADDR_W'(1);
      end
      if (tmr_q != '0) tmr_q <= tmr_q - TMR_W'(1);
    end
  end

  assign we_o    = (cnt_q != '0);
  assign waddr_o = ptr_q;
  assign busy_o  = (cnt_q != '0) || (tmr_q != '0);

  p_start_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> busy_o);

  p_fill_walks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !load) |=> (waddr_o == $past(waddr_o) + ADDR_W'(1)));

endmodule

// File: rtl/nor_dirty_track.sv
module nor_dirty_track #(
  parameter int unsigned PG_IDX_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [PG_IDX_W-1:0] page_i,
  input  logic                cs_n_i,
  output logic                commit_o,
  output logic [PG_IDX_W-1:0] commit_page_o
);
  logic                cs_n_q;
  logic                valid_q;
  logic [PG_IDX_W-1:0] dirty_q;
  logic                cs_rise;

  assign cs_rise = cs_n_i && !cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q        <= 1'b1;
      valid_q       <= 1'b0;
      dirty_q       <= '0;
      commit_o      <= 1'b0;
      commit_page_o <= '0;
    end else begin
      cs_n_q   <= cs_n_i;
      commit_o <= 1'b0;
      if (wr_i) begin
        if (valid_q && (dirty_q != page_i)) begin
          commit_o      <= 1'b1;
          commit_page_o <= dirty_q;
        end
        dirty_q <= page_i;
        valid_q <= 1'b1;
      end else if (cs_rise && valid_q) begin
        commit_o      <= 1'b1;
        commit_page_o <= dirty_q;
        valid_q       <= 1'b0;
      end
    end
  end

  p_commit_needs_dirty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(valid_q));

  p_release_cleans_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && !wr_i) |=> !valid_q);

endmodule

// File: rtl/nor_array_engine.sv
module nor_array_engine
  import nor_eng_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned PAGE_W      = 8,
  parameter int unsigned SUB_W       = 8,
  parameter int unsigned MID_W       = 9,
  parameter int unsigned SECT_W      = 10,
  parameter int unsigned BUSY_CYCLES = 64,
  parameter bit          CAP_SUB     = 1'b1,
  parameter bit          CAP_MID     = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_n_i,
  input  logic                     wr_en_i,
  input  logic                     ovw_mode_i,
  input  logic                     prog_req_i,
  input  logic [ADDR_W-1:0]        prog_addr_i,
  input  logic [2:0]               prog_off_i,
  input  logic [3:0]               prog_nbits_i,
  input  logic [7:0]               prog_data_i,
  input  logic                     erase_req_i,
  input  logic [7:0]               erase_op_i,
  input  logic [ADDR_W-1:0]        erase_addr_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o,
  output logic                     erase_err_o,
  output logic                     warn_o,
  output logic                     commit_o,
  output logic [ADDR_W-PAGE_W-1:0] commit_page_o
);
  localparam int unsigned MEM_BYTES = 1 << ADDR_W;
  localparam int unsigned PG_IDX_W  = ADDR_W - PAGE_W;

  logic [7:0]        mem_q [MEM_BYTES];
  ers_kind_e         kind;
  logic              ers_accept;
  logic              ers_start;
  logic              ers_we;
  logic [ADDR_W-1:0] ers_waddr;
  logic              ers_busy;
  logic [7:0]        old_byte;
  logic [7:0]        new_byte;
  logic              legal;
  logic              rise;
  logic              prog_fire;
  logic              unsup;

  assign kind       = decode_erase(erase_op_i);
  assign ers_accept = erase_req_i && !ers_busy && (kind != EK_NONE);
  assign ers_start  = ers_accept && wr_en_i;
  assign unsup      = ((kind == EK_SUB) && !CAP_SUB) || ((kind == EK_MID) && !CAP_MID);
  assign old_byte   = mem_q[prog_addr_i];
  assign prog_fire  = prog_req_i && wr_en_i && !cs_n_i && !ers_busy && !erase_req_i && legal;
  assign busy_o     = ers_busy;

  nor_bit_merge u_merge (
    .old_i   (old_byte),
    .data_i  (prog_data_i),
    .off_i   (prog_off_i),
    .nbits_i (prog_nbits_i),
    .ovw_i   (ovw_mode_i),
    .legal_o (legal),
    .new_o   (new_byte),
    .rise_o  (rise)
  );

  nor_erase_seq #(
    .ADDR_W      (ADDR_W),
    .SUB_W       (SUB_W),
    .MID_W       (MID_W),
    .SECT_W      (SECT_W),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_erase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ers_start),
    .kind_i  (kind),
    .addr_i  (erase_addr_i),
    .we_o    (ers_we),
    .waddr_o (ers_waddr),
    .busy_o  (ers_busy)
  );

  nor_dirty_track #(
    .PG_IDX_W (PG_IDX_W)
  ) u_dirty (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (prog_fire),
    .page_i        (prog_addr_i[ADDR_W-1:PAGE_W]),
    .cs_n_i        (cs_n_i),
    .commit_o      (commit_o),
    .commit_page_o (commit_page_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (ers_we) begin
      mem_q[ers_waddr] <= 8'hFF;
    end else if (prog_fire) begin
      mem_q[prog_addr_i] <= new_byte;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o   <= 8'hFF;
      erase_err_o <= 1'b0;
      warn_o      <= 1'b0;
    end else begin
      rd_data_o   <= mem_q[rd_addr_i];
      erase_err_o <= ers_accept && unsup;
      if (prog_fire && rise) warn_o <= 1'b1;
    end
  end

  p_fill_ff_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_we |=> (mem_q[$past(ers_waddr)] == 8'hFF));

  p_protect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_i && !wr_en_i && !busy_o) |=> !busy_o);

  p_err_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_err_o |=> !erase_err_o);

  p_and_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_fire && !ovw_mode_i) |=> ((mem_q[$past(prog_addr_i)] & ~$past(old_byte)) == 8'h00));

  p_warn_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |=> warn_o);

endmodule

// File: tb/nor_array_engine_tb.sv
`timescale 1ns/1ps
module nor_array_engine_tb;
  localparam int AW = 10;
  localparam int PW = 5;
  localparam int MEMB = 1 << AW;
  localparam int BUSY = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_en = 1'b0, ovw = 1'b0;
  logic prog_req = 1'b0, erase_req = 1'b0;
  logic [AW-1:0] prog_addr = '0, erase_addr = '0, rd_addr = '0;
  logic [2:0] prog_off = '0;
  logic [3:0] prog_nbits = 4'd8;
  logic [7:0] prog_data = '0, erase_op = '0;
  logic [7:0] rd_data;
  logic busy, err, warn, commit;
  logic [AW-PW-1:0] commit_page;

  always #10 clk = ~clk;

  nor_array_engine #(
    .ADDR_W(AW), .PAGE_W(PW), .SUB_W(6), .MID_W(7), .SECT_W(8),
    .BUSY_CYCLES(BUSY), .CAP_SUB(1'b1), .CAP_MID(1'b0)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .wr_en_i(wr_en), .ovw_mode_i(ovw),
    .prog_req_i(prog_req), .prog_addr_i(prog_addr), .prog_off_i(prog_off),
    .prog_nbits_i(prog_nbits), .prog_data_i(prog_data),
    .erase_req_i(erase_req), .erase_op_i(erase_op), .erase_addr_i(erase_addr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy), .erase_err_o(err),
    .warn_o(warn), .commit_o(commit), .commit_page_o(commit_page)
  );

  // behavioural reference state
  logic [7:0] mem_m [MEMB];
  int fill_left, fill_ptr, tmr;
  bit warn_m, dv, exp_commit, exp_err, csn_prev;
  int dpage, exp_cpage;
  logic [7:0] exp_rd;
  int vectors = 0, miscompares = 0;
  string tag = "R13";

  task automatic model_reset();
    for (int i = 0; i < MEMB; i++) mem_m[i] = 8'hFF;
    fill_left = 0; fill_ptr = 0; tmr = 0;
    warn_m = 0; dv = 0; dpage = 0; exp_commit = 0; exp_cpage = 0;
    exp_err = 0; exp_rd = 8'hFF; csn_prev = 1;
  endtask

  task automatic model_step();
    bit busy_pre;
    int len;
    busy_pre = (fill_left > 0) || (tmr > 0);
    exp_rd = mem_m[rd_addr];
    exp_commit = 0;
    exp_err = 0;
    if (fill_left > 0) begin
      mem_m[fill_ptr] = 8'hFF;
      fill_ptr++;
      fill_left--;
    end
    if (tmr > 0) tmr--;
    len = 0;
    case (erase_op)
      8'h20: len = 64;
      8'h52: len = 128;
      8'hD8, 8'hDC: len = 256;
      8'h60, 8'hC7: len = MEMB;
      default: len = 0;
    endcase
    if (erase_req && !busy_pre && len != 0) begin
      exp_err = (erase_op == 8'h52);
      if (wr_en) begin
        fill_ptr = (int'(erase_addr) / len) * len;
        fill_left = len;
        tmr = BUSY;
      end
    end else if (prog_req && wr_en && !cs_n && !busy_pre && !erase_req &&
                 prog_nbits >= 1 && prog_nbits <= 8 && int'(prog_off) + int'(prog_nbits) <= 8) begin
      int sh;
      logic [7:0] mask, d, old;
      int pg;
      sh = 8 - int'(prog_off) - int'(prog_nbits);
      mask = 8'(((1 << prog_nbits) - 1) << sh);
      d = 8'(prog_data << sh) & mask;
      old = mem_m[prog_addr];
      if (ovw) mem_m[prog_addr] = (old & ~mask) | d;
      else begin
        mem_m[prog_addr] = old & (d | ~mask);
        if ((~old & d) != 0) warn_m = 1;
      end
      pg = int'(prog_addr) >> PW;
      if (dv && dpage != pg) begin exp_commit = 1; exp_cpage = dpage; end
      dpage = pg; dv = 1;
    end else if (cs_n && !csn_prev && dv) begin
      exp_commit = 1; exp_cpage = dpage; dv = 0;
    end
    csn_prev = cs_n;
  endtask

  task automatic chk(string field, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, field, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #5;
    chk("busy_o", busy, int'((fill_left > 0) || (tmr > 0)));
    chk("erase_err_o", err, exp_err);
    chk("warn_o", warn, warn_m);
    chk("commit_o", commit, exp_commit);
    if (exp_commit) chk("commit_page_o", commit_page, exp_cpage);
    chk("rd_data_o", rd_data, exp_rd);
  endtask

  task automatic prog(int a, int off, int n, int d);
    prog_addr = AW'(a); prog_off = 3'(off); prog_nbits = 4'(n); prog_data = 8'(d);
    prog_req = 1; rd_addr = AW'(a);
    tick();
    prog_req = 0;
    tick(); tick();
  endtask

  task automatic erase(int op, int a);
    erase_op = 8'(op); erase_addr = AW'(a); erase_req = 1;
    tick();
    erase_req = 0;
  endtask

  task automatic wait_idle();
    while ((fill_left > 0) || (tmr > 0)) tick();
    tick();
  endtask

  task automatic sweep();
    for (int a = 0; a < MEMB; a++) begin rd_addr = AW'(a); tick(); end
    tick();
  endtask

  task automatic seed_pattern();
    for (int a = 0; a < MEMB; a += 23) prog(a, 0, 8, a ^ 8'h3C);
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    tag = "R13"; sweep();

    cs_n = 0; wr_en = 1;
    tag = "R6";  prog(16, 0, 8, 8'hA5); prog(16, 0, 8, 8'hF0);
    tag = "R10"; prog(17, 0, 8, 8'h0F); prog(17, 0, 8, 8'hF0);
    tag = "R8";  prog(32, 2, 3, 3'b010); prog(33, 5, 3, 8'hF8);
    prog(34, 6, 4, 8'h00); prog(35, 0, 0, 8'h00); prog(36, 7, 1, 0);
    tag = "R7";  ovw = 1; prog(16, 0, 8, 8'h5A); prog(32, 0, 4, 4'hF); ovw = 0;
    tag = "R11"; prog(40, 0, 8, 8'h11); prog(40, 0, 8, 8'h01); prog(100, 0, 8, 8'h22);
    tag = "R12"; cs_n = 1; tick(); tick(); cs_n = 0; tick(); cs_n = 1; tick(); tick(); cs_n = 0;
    tag = "R9";  wr_en = 0; prog(50, 0, 8, 8'h00); wr_en = 1;
    cs_n = 1; prog(51, 0, 8, 8'h00); cs_n = 0;
    prog_addr = 52; prog_data = 0; prog_nbits = 8; prog_off = 0; prog_req = 1;
    erase_req = 1; erase_op = 8'h33; tick(); prog_req = 0; erase_req = 0; tick();
    tag = "R2";  erase(8'h33, 0); tick(); erase(8'h00, 0); tick();
    seed_pattern();
    tag = "R3";  wr_en = 0; erase(8'hD8, 0); tick(); erase(8'h60, 0); tick(); wr_en = 1;
    tag = "R1";  erase(8'h20, 8'h55); tag = "R5";
    prog(70, 0, 8, 8'h00); erase(8'hD8, 0); wait_idle();
    tag = "R1";  sweep();
    tag = "R4";  wr_en = 0; erase(8'h52, 300); tick(); wr_en = 1;
    erase(8'h52, 300); wait_idle(); tag = "R1"; sweep();
    seed_pattern();
    tag = "R2";  erase(8'hD8, 511); wait_idle(); erase(8'hDC, 700); wait_idle(); sweep();
    seed_pattern();
    erase(8'h60, 123); wait_idle(); sweep();
    seed_pattern();
    erase(8'hC7, 0); wait_idle(); sweep();
    tag = "R12"; cs_n = 1; tick(); tick();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule